// File: doc/BRIEF.md
# Lockable Watchdog Timer with Feed Sequence

The block is a watchdog for a processor subsystem. A 32-bit down-counter advances once for every four pulses of a watchdog tick. The tick is a single-cycle strobe in the bus clock domain, one pulse per period of the selected watchdog clock. Firmware services the watchdog by writing a two-word feed sequence to a feed register. A correct sequence reloads the counter from a timeout register.

Firmware may set the enable and the reset-mode bits at any time, but it can never clear them. Both bits take effect at the next correct feed. From then on the timeout and clock-select registers no longer accept writes. A fault is raised when the count runs out, or when a feed sequence is wrong or broken off while the watchdog is running. In reset mode a fault gives a one-cycle reset request, and the block returns to its reset state except for a sticky flag that records the cause. In interrupt mode a fault latches an interrupt line instead.

The block also drives the select code for the external clock multiplexer.

Top module: `wdog_guard`

## Requirements
- R1: After `rst`, the registers read as follows: control (address 0) reads 0, timeout (address 1) reads 256, count (address 3) reads 256 and clock select (address 4) reads 0. `wd_reset_req` and `wd_irq` are low.
- R2: A write to the timeout register with a value below 256 stores 256. Any other value is stored as written.
- R3: A valid feed reloads the counter from the timeout register and clears the divide-by-4 prescaler. A valid feed is a write of 0xAA to the low byte of address 2, with the next bus access being a write of 0x55 to the same address. The reloaded value is readable on the following cycle.
- R4: Control bit 0 is the enable and bit 1 selects reset mode. A 1 written to either bit sets it, and writing 0 does not clear it. The counter runs only after a valid feed made while the enable is set. The mode in force is the one captured at the latest valid feed.
- R5: While running, the count falls by one on every fourth `wd_tick` pulse. A counter loaded with N reaches 0 on the 4N-th tick after the feed.
- R6: In reset mode, a fault sets `wd_reset_req` high for exactly one cycle. At that same edge every register returns to its R1 value, except that control bit 2 becomes 1.
- R7: In interrupt mode, a fault sets `wd_irq` high, and it stays high until a reset. After expiry the count holds at 0.
- R8: While the watchdog is running, either of the following is a fault: a feed-register write other than 0xAA when no sequence is open, or any bus access other than a write of 0x55 to the feed register after an accepted 0xAA. When the watchdog is not running, such a sequence is dropped with no other effect.
- R9: Once the watchdog is running, writes to the timeout and clock-select registers are ignored, and a write of 0 to control leaves the enable set.
- R10: Control bit 2 (watchdog-reset flag) is set by a watchdog reset. It is cleared by a control write with bit 2 at 0, or by `rst`. A control write with bit 2 at 1 leaves it unchanged.
- R11: Clock-select bits [1:0] drive `wd_clk_sel`: 0 selects the internal RC oscillator, 1 the peripheral bus clock and 2 the RTC clock. Code 3 is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | External hardware reset, synchronous, active high |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wd_tick | input | 1 | One pulse per watchdog clock period |
| wd_clk_sel | output | 2 | Watchdog clock multiplexer select |
| wd_reset_req | output | 1 | One-cycle watchdog reset request |
| wd_irq | output | 1 | Latched watchdog interrupt |

## Verification
Read data is combinational, so a read shows the state left by the previous edge. A register write, a feed reload and a prescaled decrement are therefore due on a read in the cycle after the access or tick that causes them. A reset request or interrupt is due in the cycle after the faulting access, or after the last tick. The bench drives every input just after a falling edge and compares about 1 ns later against a behavioural model. The model advances on each rising edge, so each result is sampled exactly one edge after its cause.

// File: rtl/wdog_guard_pkg.sv
`timescale 1ns/1ps
package wdog_guard_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_LOAD  = 3'd1,
        REG_FEED  = 3'd2,
        REG_COUNT = 3'd3,
        REG_CSEL  = 3'd4
    } reg_sel_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    typedef struct packed {
        logic              hit;
        logic              wr;
        reg_sel_e          target;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic en_req;
        logic mode_req;
        logic active;
        logic mode_eff;
        logic flag;
    } ctrl_state_t;

    function automatic logic [DATA_W-1:0] clamp_load(input logic [DATA_W-1:0] v,
                                                     input logic [DATA_W-1:0] floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

endpackage

// File: rtl/wdog_feed_chk.sv
`timescale 1ns/1ps
module wdog_feed_chk
    import wdog_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  bus_req_t req,
    output logic     feed_ok,
    output logic     feed_bad
);

    logic armed;
    logic feed_wr;

    assign feed_wr = req.hit && req.wr && (req.target == REG_FEED);

    always_comb begin
        feed_ok  = armed && feed_wr && (req.data[7:0] == KEY_SECOND);
        feed_bad = 1'b0;
        if (req.hit) begin
            if (armed) feed_bad = !feed_ok;
            else       feed_bad = feed_wr && (req.data[7:0] != KEY_FIRST);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            armed <= 1'b0;
        else if (req.hit)
            armed <= !armed && feed_wr && (req.data[7:0] == KEY_FIRST);
    end

    // R3: a completed sequence always closes the window
    a_r3_ok_closes: assert property (@(posedge clk) disable iff (rst)
        feed_ok |=> !armed);

endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_guard_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int MIN_TO = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  bus_req_t         req,
    input  logic             feed_ok,
    output ctrl_state_t      st,
    output logic [CNT_W-1:0] load_q,
    output logic [1:0]       csel_q
);

    localparam logic [CNT_W-1:0] LOAD_RST = CNT_W'(MIN_TO);

    logic wr_ctrl, wr_load, wr_csel;

    assign wr_ctrl = req.hit && req.wr && (req.target == REG_CTRL);
    assign wr_load = req.hit && req.wr && (req.target == REG_LOAD);
    assign wr_csel = req.hit && req.wr && (req.target == REG_CSEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            load_q <= LOAD_RST;
            csel_q <= 2'd0;
        end else if (restart) begin
            st      <= '0;
            st.flag <= 1'b1;
            load_q  <= LOAD_RST;
            csel_q  <= 2'd0;
        end else begin
            if (wr_ctrl) begin
                st.en_req   <= st.en_req   | req.data[0];
                st.mode_req <= st.mode_req | req.data[1];
                if (!req.data[2]) st.flag <= 1'b0;
            end
            if (wr_load && !st.active)
                load_q <= clamp_load(req.data[CNT_W-1:0], LOAD_RST);
            if (wr_csel && !st.active)
                csel_q <= req.data[1:0];
            if (feed_ok) begin
                st.active   <= st.active | st.en_req;
                st.mode_eff <= st.mode_req;
            end
        end
    end

    // R4: once running, only a watchdog reset stops the counter
    a_r4_active_sticky: assert property (@(posedge clk) disable iff (rst)
        st.active && !restart |=> st.active);

    // R9: locked configuration does not move while running
    a_r9_lock_config: assert property (@(posedge clk) disable iff (rst)
        st.active && !restart |=> $stable(load_q) && $stable(csel_q));

endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 2,
    parameter int MIN_TO = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [PRE_W-1:0] PRE_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_RST  = CNT_W'(MIN_TO);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [PRE_W-1:0] pre;
    logic             step;

    assign step   = run && tick && (pre == PRE_MAX);
    assign expire = step && (count == CNT_ONE) && !reload;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= CNT_RST;
            pre   <= '0;
        end else if (reload) begin
            count <= reload_val;
            pre   <= '0;
        end else if (run && tick) begin
            pre <= pre + 1'b1;
            if (step && (count != '0))
                count <= count - 1'b1;
        end
    end

    // R2: a reload never places a value below the floor in the counter
    a_r2_reload_floor: assert property (@(posedge clk) disable iff (rst)
        reload && !restart |=> count >= CNT_RST);

    // R7: a stopped counter at zero stays at zero until reloaded
    a_r7_zero_hold: assert property (@(posedge clk) disable iff (rst)
        count == '0 && !reload && !restart |=> count == '0);

endmodule

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard
    import wdog_guard_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 2,
    parameter int MIN_TO = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wd_tick,
    output logic [1:0]        wd_clk_sel,
    output logic              wd_reset_req,
    output logic              wd_irq
);

    bus_req_t         req;
    ctrl_state_t      st;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count;
    logic [1:0]       csel_q;
    logic             feed_ok, feed_bad, expire;
    logic             fault, restart;

    always_comb begin
        req.hit    = bus_sel;
        req.wr     = bus_wr;
        req.target = reg_sel_e'(bus_addr);
        req.data   = bus_wdata;
    end

    assign fault   = st.active && (expire || feed_bad);
    assign restart = fault && st.mode_eff;

    wdog_feed_chk u_feed (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .req      (req),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdog_regs #(.CNT_W(CNT_W), .MIN_TO(MIN_TO)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .req     (req),
        .feed_ok (feed_ok),
        .st      (st),
        .load_q  (load_q),
        .csel_q  (csel_q)
    );

    wdog_count #(.CNT_W(CNT_W), .PRE_W(PRE_W), .MIN_TO(MIN_TO)) u_count (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .run        (st.active),
        .tick       (wd_tick),
        .reload     (feed_ok),
        .reload_val (load_q),
        .count      (count),
        .expire     (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_reset_req <= 1'b0;
            wd_irq       <= 1'b0;
        end else begin
            wd_reset_req <= restart;
            if (restart)    wd_irq <= 1'b0;
            else if (fault) wd_irq <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (req.target)
            REG_CTRL:  bus_rdata = {{(DATA_W-3){1'b0}}, st.flag, st.mode_req, st.en_req};
            REG_LOAD:  bus_rdata = DATA_W'(load_q);
            REG_COUNT: bus_rdata = DATA_W'(count);
            REG_CSEL:  bus_rdata = {{(DATA_W-2){1'b0}}, csel_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign wd_clk_sel = csel_q;

    // R6: the reset request is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wd_reset_req |=> !wd_reset_req);

    // R6 / R10: a reset request always leaves the cause flag set
    a_r10_flag_on_reset: assert property (@(posedge clk) disable iff (rst)
        wd_reset_req |-> st.flag);

    // R7: the interrupt only drops on a reset
    a_r7_irq_hold: assert property (@(posedge clk) disable iff (rst)
        wd_irq && !restart |=> wd_irq);

    // R1 / R6: reset request and interrupt are never high together
    a_r6_outputs_excl: assert property (@(posedge clk) disable iff (rst)
        !(wd_reset_req && wd_irq));

endmodule

// File: tb/wdog_guard_bench.sv
`timescale 1ns/1ps
module wdog_guard_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic        tick = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  clk_sel;
    logic        reset_req, irq;

    localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_FEED = 3'd2,
                           A_CNT = 3'd3, A_CSEL = 3'd4;

    wdog_guard u_wdog_guard (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (sel),
        .bus_wr       (wr),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .wd_tick      (tick),
        .wd_clk_sel   (clk_sel),
        .wd_reset_req (reset_req),
        .wd_irq       (irq)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural reference state
    bit          m_en, m_mode, m_act, m_meff, m_flag, m_irq, m_rreq, m_armed;
    logic [31:0] m_to, m_cnt;
    int          m_pre;
    logic [1:0]  m_csel;

    task automatic m_clear();
        m_en = 0; m_mode = 0; m_act = 0; m_meff = 0; m_armed = 0;
        m_to = 32'd256; m_cnt = 32'd256; m_pre = 0; m_csel = 2'd0; m_irq = 0;
    endtask

    always @(posedge clk) begin
        bit ok, bad, ex, flt;
        ok = 0; bad = 0; ex = 0;
        if (rst) begin
            m_clear();
            m_flag = 0;
            m_rreq = 0;
        end else begin
            if (sel) begin
                if (m_armed) begin
                    if (wr && addr == A_FEED && wdata[7:0] == 8'h55) ok = 1;
                    else bad = 1;
                    m_armed = 0;
                end else if (wr && addr == A_FEED) begin
                    if (wdata[7:0] == 8'hAA) m_armed = 1;
                    else bad = 1;
                end
            end
            if (m_act && tick && m_pre == 3 && m_cnt == 1 && !ok) ex = 1;
            flt = m_act && (ex || bad);
            if (flt && m_meff) begin
                m_clear();
                m_flag = 1;
                m_rreq = 1;
            end else begin
                m_rreq = 0;
                if (flt) m_irq = 1;
                if (sel && wr) begin
                    if (addr == A_CTRL) begin
                        m_en = m_en | wdata[0];
                        m_mode = m_mode | wdata[1];
                        if (!wdata[2]) m_flag = 0;
                    end else if (addr == A_LOAD && !m_act) begin
                        m_to = (wdata < 32'd256) ? 32'd256 : wdata;
                    end else if (addr == A_CSEL && !m_act) begin
                        m_csel = wdata[1:0];
                    end
                end
                if (ok) begin
                    m_cnt = m_to;
                    m_pre = 0;
                end else if (m_act && tick) begin
                    if (m_pre == 3 && m_cnt != 0) m_cnt = m_cnt - 1;
                    m_pre = (m_pre + 1) % 4;
                end
                if (ok) begin
                    m_act = m_act | m_en;
                    m_meff = m_mode;
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog R5 run hung: actual %0d cycles, expected fewer", cyc);
            summary();
            $finish;
        end
    end

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            A_CTRL: return {29'd0, m_flag, m_mode, m_en};
            A_LOAD: return m_to;
            A_CNT:  return m_cnt;
            A_CSEL: return {30'd0, m_csel};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            A_CTRL: return "R4 control read";
            A_LOAD: return "R2 timeout read";
            A_CNT:  return "R5 count read";
            A_CSEL: return "R11 clock select read";
            default: return "R3 feed read";
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit s, input bit w, input logic [2:0] a,
                        input logic [31:0] d, input bit t);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; tick = t;
        #1;
        check({31'd0, reset_req}, {31'd0, m_rreq}, "R6 reset request");
        check({31'd0, irq}, {31'd0, m_irq}, "R7 interrupt");
        check({30'd0, clk_sel}, {30'd0, m_csel}, "R11 clock select");
        if (s && !w) check(rdata, model_rd(a), rd_tag(a));
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0);
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [31:0] exp, input string tag);
        step(1, 0, a, 32'd0, 0);
        check(rdata, exp, tag);
    endtask

    task automatic idle(input int n, input bit t);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 32'd0, t);
    endtask

    task automatic feed();
        wr_reg(A_FEED, 32'hAA);
        wr_reg(A_FEED, 32'h55);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        idle(3, 0);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        do_reset();
        // R1 reset values
        rd_expect(A_CTRL, 32'd0, "R1 control after reset");
        rd_expect(A_LOAD, 32'd256, "R1 timeout after reset");
        rd_expect(A_CNT, 32'd256, "R1 count after reset");
        rd_expect(A_CSEL, 32'd0, "R1 clock select after reset");
        check({30'd0, reset_req, irq}, 32'd0, "R1 outputs after reset");

        // R2 floor on timeout
        wr_reg(A_LOAD, 32'd5);
        rd_expect(A_LOAD, 32'd256, "R2 small timeout forced");
        wr_reg(A_LOAD, 32'd255);
        rd_expect(A_LOAD, 32'd256, "R2 timeout 255 forced");
        wr_reg(A_LOAD, 32'd300);
        rd_expect(A_LOAD, 32'd300, "R2 timeout kept");

        // R11 clock select
        wr_reg(A_CSEL, 32'd3);
        idle(1, 0);
        check({30'd0, clk_sel}, 32'd3, "R11 select code 3");
        wr_reg(A_CSEL, 32'd2);
        idle(1, 0);
        check({30'd0, clk_sel}, 32'd2, "R11 select RTC");

        // R3 feed without enable reloads only
        feed();
        rd_expect(A_CNT, 32'd300, "R3 reload from timeout");
        idle(20, 1);
        rd_expect(A_CNT, 32'd300, "R4 idle while disabled");

        // R8 bad sequences while not running are harmless
        wr_reg(A_FEED, 32'h12);
        wr_reg(A_FEED, 32'hAA);
        step(1, 0, A_CTRL, 32'd0, 0);
        idle(1, 0);
        check({31'd0, irq}, 32'd0, "R8 no fault while stopped");
        rd_expect(A_CNT, 32'd300, "R8 count untouched while stopped");

        // R4 enable in interrupt mode, counting starts at the feed
        wr_reg(A_CTRL, 32'd1);
        rd_expect(A_CTRL, 32'd1, "R4 enable bit set");
        idle(8, 1);
        rd_expect(A_CNT, 32'd300, "R4 no count before feed");
        feed();
        idle(8, 1);
        rd_expect(A_CNT, 32'd298, "R5 two decrements after 8 ticks");
        for (int i = 0; i < 8; i++) step(0, 0, 3'd0, 32'd0, i[0]);
        rd_expect(A_CNT, 32'd297, "R5 sparse ticks");

        // R9 lock
        wr_reg(A_LOAD, 32'd1000);
        rd_expect(A_LOAD, 32'd300, "R9 timeout locked");
        wr_reg(A_CSEL, 32'd1);
        idle(1, 0);
        check({30'd0, clk_sel}, 32'd2, "R9 clock select locked");
        wr_reg(A_CTRL, 32'd0);
        rd_expect(A_CTRL, 32'd1, "R9 enable not clearable");

        // R8 interrupted sequence raises interrupt
        wr_reg(A_FEED, 32'hAA);
        wr_reg(A_CTRL, 32'd0);
        idle(1, 0);
        check({30'd0, reset_req, irq}, 32'd1, "R8 interrupted feed gives interrupt");

        // R5/R7 expiry in interrupt mode
        feed();
        idle(1199, 1);
        rd_expect(A_CNT, 32'd1, "R5 one before expiry");
        idle(1, 1);
        rd_expect(A_CNT, 32'd0, "R7 count at zero");
        idle(40, 1);
        rd_expect(A_CNT, 32'd0, "R7 count holds zero");
        check({31'd0, irq}, 32'd1, "R7 interrupt held");

        // R6 reset mode via bad feed
        do_reset();
        wr_reg(A_CTRL, 32'd3);
        feed();
        idle(10, 1);
        wr_reg(A_FEED, 32'h12);
        rd_expect(A_CTRL, 32'd4, "R10 flag set by watchdog reset");
        check({31'd0, reset_req}, 32'd1, "R6 reset request after bad feed");
        rd_expect(A_LOAD, 32'd256, "R6 timeout restored");
        check({31'd0, reset_req}, 32'd0, "R6 request lasts one cycle");
        rd_expect(A_CNT, 32'd256, "R6 count restored");

        // R10 flag kept by bit2=1, then expiry in reset mode
        wr_reg(A_CTRL, 32'd4);
        rd_expect(A_CTRL, 32'd4, "R10 flag kept");
        wr_reg(A_CTRL, 32'd7);
        feed();
        idle(1024, 1);
        rd_expect(A_CTRL, 32'd4, "R6 controls cleared at expiry");
        check({31'd0, reset_req}, 32'd1, "R6 reset request after expiry");
        wr_reg(A_CTRL, 32'd0);
        rd_expect(A_CTRL, 32'd0, "R10 flag cleared by software");

        // R10 external reset clears flag
        wr_reg(A_CTRL, 32'd3);
        feed();
        wr_reg(A_FEED, 32'd0);
        rd_expect(A_CTRL, 32'd4, "R10 flag set again");
        do_reset();
        rd_expect(A_CTRL, 32'd0, "R10 flag cleared by reset");

        summary();
        $finish;
    end

endmodule